// File: doc/BRIEF.md
# Dual-channel DAC input interface

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. It takes parallel data words and delivers one latched code per channel to the current-switch decoders. It also delivers the complement of each code and a registered power-down flag. Everything runs on one system clock, `clk`. The write strobes and the update clocks of the converter arrive as level inputs. The block samples them on `clk` and acts on their edges.

When `mode_dual_i` is high, the two channels are independent. Each has its own bus, its own write strobe (which loads an input hold register) and its own update clock (which advances a fixed-depth pipeline towards the output). When `mode_dual_i` is low, the block runs interleaved. Bus A carries I and Q words one after the other. The pin `wr_b_sel_i` becomes the steering select and `upd_b_align_i` becomes the phase-alignment input. The update clock on `upd_a_i` is divided by two before it advances both channel pipelines together. Sleep freezes the codes and ignores writes.

Top module: `dual_dac_frontend`

## Requirements
- R1: A synchronous reset clears both codes to 0, both complement outputs to 4095 and the sleep flag to 0. It also clears every hold register and pipeline stage and the divide-by-two phase.
- R2: With `mode_dual_i`=1, a rising edge on `wr_a_i` captures `bus_a_i`. That word appears on `code_a_o` after the 4th rising edge of `upd_a_i` that comes strictly after the write. A `upd_a_i` edge in the same cycle as the write does not count.
- R3: With `mode_dual_i`=1, channel B follows R2 using `bus_b_i`, `wr_b_sel_i` and `upd_b_align_i`. A channel's code never changes in a cycle with no rising edge on that channel's own update clock.
- R4: With `mode_dual_i`=0, a rising edge on `wr_a_i` loads `bus_a_i` into the I hold when `wr_b_sel_i` is 1, and into the Q hold when it is 0. The other hold keeps its value.
- R5: With `mode_dual_i`=0, a falling edge on `wr_a_i` copies the I and Q holds into a pair register. The divided clock toggles on each rising edge of `upd_a_i`, and each 0-to-1 toggle shifts the pair into both pipelines. The pair reaches `code_a_o` (I) and `code_b_o` (Q) on the 4th such update.
- R6: With `mode_dual_i`=0, while `upd_b_align_i` is 1 the divided clock is held at 0 and no update occurs. After release, the first `upd_a_i` rising edge is an update.
- R7: With `mode_dual_i`=0, `bus_b_i` has no effect on any output.
- R8: `code_a_n_o` equals 4095 minus `code_a_o`, and `code_b_n_o` equals 4095 minus `code_b_o`, at all times.
- R9: While `sleep_i` is 1, both codes hold, and writes and update edges are ignored: a word written during sleep never reaches an output. `asleep_o` equals `sleep_i` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_dual_i | input | 1 | 1 = dual-bus mode, 0 = single-bus interleaved mode |
| sleep_i | input | 1 | Power-down request, active high |
| bus_a_i | input | 12 | Channel A data, or the interleaved I/Q data |
| bus_b_i | input | 12 | Channel B data (dual mode only) |
| wr_a_i | input | 1 | Write strobe for A, or the shared write strobe |
| wr_b_sel_i | input | 1 | Write strobe for B, or the I/Q select level |
| upd_a_i | input | 1 | Update clock for A, or the shared update clock |
| upd_b_align_i | input | 1 | Update clock for B, or the divider phase-alignment level |
| code_a_o | output | 12 | Latched code for channel A / I |
| code_a_n_o | output | 12 | Complement of code_a_o |
| code_b_o | output | 12 | Latched code for channel B / Q |
| code_b_n_o | output | 12 | Complement of code_b_o |
| asleep_o | output | 1 | Registered sleep flag |

## Verification
The hardest state to reach from the ports is a known phase of the divided update clock relative to a freshly paired I/Q word. An odd number of clock edges leaves the phase at 1, and only a correct alignment makes the fourth update land on the seventh edge. The stimulus first leaves the divider at phase 1. It then holds the alignment input while it keeps pulsing the update clock, checks that nothing moves, and counts edges after release to show exactly when the new pair arrives. A long random phase then varies mode, sleep, select and alignment, and compares every cycle against a bench model.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    typedef enum logic {
        BUS_INTERLEAVED = 1'b0,
        BUS_DUAL        = 1'b1
    } bus_mode_e;

    // Positions of the sampled strobes inside the edge-tracker vector.
    localparam int STROBE_N = 4;
    localparam int S_WR_A   = 0;
    localparam int S_WR_B   = 1;
    localparam int S_UPD_A  = 2;
    localparam int S_UPD_B  = 3;

    localparam int CHAN_N   = 2;

endpackage

// File: rtl/dacif_edge_det.sv
module dacif_edge_det #(
    parameter int N        = 4,
    parameter int FALL_IDX = 0
) (
    input  logic         clk,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic         fall_o
);

    typedef struct packed {
        logic [N-1:0] prev;
    } state_t;

    state_t s_d, s_q;

    // Trackers follow the inputs at all times so an edge is never invented
    // when reset or sleep ends.
    always_comb begin
        s_d      = s_q;
        s_d.prev = lvl_i;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_rise
            assign rise_o[g] = lvl_i[g] & ~s_q.prev[g];
        end
    endgenerate

    assign fall_o = ~lvl_i[FALL_IDX] & s_q.prev[FALL_IDX];

endmodule

// File: rtl/dacif_input_stage.sv
module dacif_input_stage
    import dacif_pkg::*;
#(
    parameter int W = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  bus_mode_e mode_i,
    input  logic      sleep_i,
    input  logic [W-1:0] bus_a_i,
    input  logic [W-1:0] bus_b_i,
    input  logic      sel_i,
    input  logic      align_i,
    input  logic      wr_a_rise_i,
    input  logic      wr_a_fall_i,
    input  logic      wr_b_rise_i,
    input  logic      upd_a_rise_i,
    input  logic      upd_b_rise_i,
    output logic [W-1:0] src_a_o,
    output logic [W-1:0] src_b_o,
    output logic      shift_a_o,
    output logic      shift_b_o
);

    typedef struct packed {
        logic [W-1:0] hold_a;   // channel A hold, or the I hold
        logic [W-1:0] hold_b;   // channel B hold, or the Q hold
        logic [W-1:0] pair_a;   // I word of the pair handed to the DAC latches
        logic [W-1:0] pair_b;   // Q word of the pair
        logic         div;      // divide-by-two phase of the update clock
    } state_t;

    state_t s_d, s_q;
    logic   dual;
    logic   run;
    logic   div_rise;

    always_comb begin
        dual     = (mode_i == BUS_DUAL);
        run      = ~sleep_i;
        div_rise = ~dual & ~align_i & upd_a_rise_i & ~s_q.div;

        s_d = s_q;
        if (run) begin
            if (dual) begin
                if (wr_a_rise_i) s_d.hold_a = bus_a_i;
                if (wr_b_rise_i) s_d.hold_b = bus_b_i;
                s_d.div = 1'b0;
            end else begin
                if (wr_a_rise_i) begin
                    if (sel_i) s_d.hold_a = bus_a_i;
                    else       s_d.hold_b = bus_a_i;
                end
                if (wr_a_fall_i) begin
                    s_d.pair_a = s_q.hold_a;
                    s_d.pair_b = s_q.hold_b;
                end
                if (align_i)           s_d.div = 1'b0;
                else if (upd_a_rise_i) s_d.div = ~s_q.div;
            end
        end
        if (rst) s_d = '0;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign src_a_o   = dual ? s_q.hold_a : s_q.pair_a;
    assign src_b_o   = dual ? s_q.hold_b : s_q.pair_b;
    assign shift_a_o = run & (dual ? upd_a_rise_i : div_rise);
    assign shift_b_o = run & (dual ? upd_b_rise_i : div_rise);

endmodule

// File: rtl/dacif_core_pipe.sv
module dacif_core_pipe #(
    parameter int W   = 12,
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_i,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] code_o
);

    typedef struct packed {
        logic [LAT-1:0][W-1:0] stg;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (shift_i) begin
            s_d.stg[0] = src_i;
            for (int i = 1; i < LAT; i++) begin
                s_d.stg[i] = s_q.stg[i-1];
            end
        end
        if (rst) s_d = '0;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign code_o = s_q.stg[LAT-1];

endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
    import dacif_pkg::*;
#(
    parameter int W   = 12,
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode_dual_i,
    input  logic         sleep_i,
    input  logic [W-1:0] bus_a_i,
    input  logic [W-1:0] bus_b_i,
    input  logic         wr_a_i,
    input  logic         wr_b_sel_i,
    input  logic         upd_a_i,
    input  logic         upd_b_align_i,
    output logic [W-1:0] code_a_o,
    output logic [W-1:0] code_a_n_o,
    output logic [W-1:0] code_b_o,
    output logic [W-1:0] code_b_n_o,
    output logic         asleep_o
);

    localparam logic [W-1:0] FULL = '1;

    typedef struct packed {
        logic asleep;
    } state_t;

    state_t s_d, s_q;

    logic [STROBE_N-1:0] lvl;
    logic [STROBE_N-1:0] rise;
    logic                wr_a_fall;
    logic [W-1:0]        src   [CHAN_N];
    logic                shift [CHAN_N];
    logic [W-1:0]        code  [CHAN_N];

    assign lvl[S_WR_A]  = wr_a_i;
    assign lvl[S_WR_B]  = wr_b_sel_i;
    assign lvl[S_UPD_A] = upd_a_i;
    assign lvl[S_UPD_B] = upd_b_align_i;

    dacif_edge_det #(
        .N        (STROBE_N),
        .FALL_IDX (S_WR_A)
    ) edge_i (
        .clk    (clk),
        .lvl_i  (lvl),
        .rise_o (rise),
        .fall_o (wr_a_fall)
    );

    dacif_input_stage #(
        .W (W)
    ) in_i (
        .clk          (clk),
        .rst          (rst),
        .mode_i       (bus_mode_e'(mode_dual_i)),
        .sleep_i      (sleep_i),
        .bus_a_i      (bus_a_i),
        .bus_b_i      (bus_b_i),
        .sel_i        (wr_b_sel_i),
        .align_i      (upd_b_align_i),
        .wr_a_rise_i  (rise[S_WR_A]),
        .wr_a_fall_i  (wr_a_fall),
        .wr_b_rise_i  (rise[S_WR_B]),
        .upd_a_rise_i (rise[S_UPD_A]),
        .upd_b_rise_i (rise[S_UPD_B]),
        .src_a_o      (src[0]),
        .src_b_o      (src[1]),
        .shift_a_o    (shift[0]),
        .shift_b_o    (shift[1])
    );

    generate
        for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
            dacif_core_pipe #(
                .W   (W),
                .LAT (LAT)
            ) pipe_i (
                .clk     (clk),
                .rst     (rst),
                .shift_i (shift[c]),
                .src_i   (src[c]),
                .code_o  (code[c])
            );
        end
    endgenerate

    always_comb begin
        s_d        = s_q;
        s_d.asleep = sleep_i;
        if (rst) s_d = '0;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign code_a_o   = code[0];
    assign code_b_o   = code[1];
    assign code_a_n_o = FULL - code[0];
    assign code_b_n_o = FULL - code[1];
    assign asleep_o   = s_q.asleep;

endmodule

// File: rtl/dacif_checker.sv
module dacif_checker #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         mode_dual_i,
    input logic         sleep_i,
    input logic         upd_a_i,
    input logic         upd_b_align_i,
    input logic [W-1:0] code_a_o,
    input logic [W-1:0] code_a_n_o,
    input logic [W-1:0] code_b_o,
    input logic [W-1:0] code_b_n_o,
    input logic         asleep_o
);

    localparam logic [W:0] FULL_X = {1'b0, {W{1'b1}}};

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code_a_o == '0) && (code_b_o == '0) && !asleep_o);

    assert_complement_R8: assert property (@(posedge clk) disable iff (rst)
        (({1'b0, code_a_o} + {1'b0, code_a_n_o}) == FULL_X) &&
        (({1'b0, code_b_o} + {1'b0, code_b_n_o}) == FULL_X));

    assert_dual_hold_a_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_dual_i && !(upd_a_i && !$past(upd_a_i))) |=> $stable(code_a_o));

    assert_dual_hold_b_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_dual_i && !(upd_b_align_i && !$past(upd_b_align_i))) |=> $stable(code_b_o));

    assert_align_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!mode_dual_i && upd_b_align_i) |=> ($stable(code_a_o) && $stable(code_b_o)));

    assert_sleep_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> ($stable(code_a_o) && $stable(code_b_o)));

    assert_sleep_flag_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (asleep_o == $past(sleep_i)));

endmodule

bind dual_dac_frontend dacif_checker #(.W(W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .mode_dual_i   (mode_dual_i),
    .sleep_i       (sleep_i),
    .upd_a_i       (upd_a_i),
    .upd_b_align_i (upd_b_align_i),
    .code_a_o      (code_a_o),
    .code_a_n_o    (code_a_n_o),
    .code_b_o      (code_b_o),
    .code_b_n_o    (code_b_n_o),
    .asleep_o      (asleep_o)
);

// File: tb/dual_dac_frontend_tb_top.sv
module dual_dac_frontend_tb_top;

    localparam int W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_dual = 1'b1;
    logic sleep = 1'b0;
    logic [W-1:0] bus_a = '0;
    logic [W-1:0] bus_b = '0;
    logic wr_a = 1'b0, wr_b = 1'b0, upd_a = 1'b0, upd_b = 1'b0;
    logic [W-1:0] code_a, code_a_n, code_b, code_b_n;
    logic asleep;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;   // 50 MHz

    dual_dac_frontend dut_i (
        .clk           (clk),
        .rst           (rst),
        .mode_dual_i   (mode_dual),
        .sleep_i       (sleep),
        .bus_a_i       (bus_a),
        .bus_b_i       (bus_b),
        .wr_a_i        (wr_a),
        .wr_b_sel_i    (wr_b),
        .upd_a_i       (upd_a),
        .upd_b_align_i (upd_b),
        .code_a_o      (code_a),
        .code_a_n_o    (code_a_n),
        .code_b_o      (code_b),
        .code_b_n_o    (code_b_n),
        .asleep_o      (asleep)
    );

    // Reference model built from the requirements.
    logic pw_a = 0, pw_b = 0, pu_a = 0, pu_b = 0;
    logic [W-1:0] m_ha = 0, m_hb = 0, m_pi = 0, m_pq = 0;
    logic [W-1:0] m_sa [4];
    logic [W-1:0] m_sb [4];
    logic m_div = 0, m_sleep = 0;

    function automatic logic [W-1:0] exp_comp(input logic [W-1:0] c);
        return W'(4095 - int'(c));
    endfunction

    always @(posedge clk) begin
        logic ra, fa, rb, rua, rub, sa, sb;
        logic [W-1:0] srca, srcb;
        ra  = wr_a & ~pw_a;  fa = ~wr_a & pw_a;  rb = wr_b & ~pw_b;
        rua = upd_a & ~pu_a; rub = upd_b & ~pu_b;
        pw_a = wr_a; pw_b = wr_b; pu_a = upd_a; pu_b = upd_b;
        sa = 0; sb = 0; srca = 0; srcb = 0;
        if (rst) begin
            m_ha = 0; m_hb = 0; m_pi = 0; m_pq = 0; m_div = 0; m_sleep = 0;
            for (int i = 0; i < 4; i++) begin m_sa[i] = 0; m_sb[i] = 0; end
        end else begin
            m_sleep = sleep;
            if (!sleep) begin
                if (mode_dual) begin
                    sa = rua; sb = rub; srca = m_ha; srcb = m_hb;
                    if (ra) m_ha = bus_a;
                    if (rb) m_hb = bus_b;
                    m_div = 0;
                end else begin
                    sa = !upd_b && rua && !m_div; sb = sa;
                    srca = m_pi; srcb = m_pq;
                    if (fa) begin m_pi = m_ha; m_pq = m_hb; end
                    if (ra) begin
                        if (wr_b) m_ha = bus_a; else m_hb = bus_a;
                    end
                    if (upd_b) m_div = 0; else if (rua) m_div = !m_div;
                end
                if (sa) begin
                    for (int i = 3; i > 0; i--) m_sa[i] = m_sa[i-1];
                    m_sa[0] = srca;
                end
                if (sb) begin
                    for (int i = 3; i > 0; i--) m_sb[i] = m_sb[i-1];
                    m_sb[0] = srcb;
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic pwa, input logic pwb, input logic pua, input logic pub);
        if (pwa) wr_a = 1; if (pwb) wr_b = 1; if (pua) upd_a = 1; if (pub) upd_b = 1;
        step();
        if (pwa) wr_a = 0; if (pwb) wr_b = 0; if (pua) upd_a = 0; if (pub) upd_b = 0;
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd20240611));
        repeat (3) step();
        rst = 0;
        step();
        // R1 reset state
        chk("R1 code_a", code_a, 12'h000);
        chk("R1 code_b", code_b, 12'h000);
        chk("R1 code_a_n", code_a_n, 12'hFFF);
        chk("R1 asleep", {11'd0, asleep}, 12'h000);

        // R2 dual mode latency on channel A
        bus_a = 12'hABC;
        pulse(1, 0, 1, 0);
        bus_a = 12'h111;
        repeat (3) pulse(0, 0, 1, 0);
        chk("R2 before 4th update", code_a, 12'h000);
        pulse(0, 0, 1, 0);
        chk("R2 after 4th update", code_a, 12'hABC);
        chk("R8 complement a", code_a_n, exp_comp(12'hABC));
        chk("R3 b untouched by a", code_b, 12'h000);

        // R3 channel B on its own strobes
        bus_b = 12'h9D2;
        pulse(0, 1, 0, 1);
        repeat (3) pulse(0, 0, 0, 1);
        chk("R3 b before 4th update", code_b, 12'h000);
        pulse(0, 0, 0, 1);
        chk("R3 b after 4th update", code_b, 12'h9D2);
        chk("R3 a untouched by b", code_a, 12'hABC);

        // R4/R5/R7 interleaved pairing
        mode_dual = 0; upd_b = 1; bus_b = 12'hFFF;
        step(); step();
        wr_b = 1; bus_a = 12'h5A5; pulse(1, 0, 0, 0);
        wr_b = 0; bus_a = 12'h3C3; pulse(1, 0, 0, 0);
        bus_a = 12'h000; upd_b = 0;
        repeat (5) pulse(0, 0, 1, 0);
        chk("R5 three updates a", code_a, 12'hABC);
        chk("R5 three updates b", code_b, 12'h9D2);
        pulse(0, 0, 1, 0);
        chk("R5 no update on falling phase", code_a, 12'hABC);
        pulse(0, 0, 1, 0);
        chk("R4 I word on a", code_a, 12'h5A5);
        chk("R4 Q word on b", code_b, 12'h3C3);
        chk("R7 bus_b ignored", code_b_n, exp_comp(12'h3C3));

        // R6 alignment from a divider left at phase 1
        wr_b = 1; bus_a = 12'h0F0; pulse(1, 0, 0, 0);
        wr_b = 0; bus_a = 12'h70E; pulse(1, 0, 0, 0);
        upd_b = 1;
        repeat (8) pulse(0, 0, 1, 0);
        chk("R6 held while aligning", code_a, 12'h5A5);
        upd_b = 0;
        repeat (5) pulse(0, 0, 1, 0);
        chk("R6 three updates after release", code_a, 12'h5A5);
        repeat (2) pulse(0, 0, 1, 0);
        chk("R6 fourth update a", code_a, 12'h0F0);
        chk("R6 fourth update b", code_b, 12'h70E);

        // R9 sleep
        mode_dual = 1; bus_a = 12'h246;
        pulse(1, 0, 1, 0);
        repeat (4) pulse(0, 0, 1, 0);
        chk("R2 dual after interleave", code_a, 12'h246);
        sleep = 1; step();
        chk("R9 flag set", {11'd0, asleep}, 12'h001);
        bus_a = 12'h777;
        pulse(1, 0, 1, 0);
        repeat (4) pulse(0, 0, 1, 0);
        chk("R9 frozen in sleep", code_a, 12'h246);
        sleep = 0; step();
        repeat (4) pulse(0, 0, 1, 0);
        chk("R9 sleep write ignored", code_a, 12'h246);
        chk("R9 flag clear", {11'd0, asleep}, 12'h000);

        // Random phase against the model (R2 R3 R4 R5 R6 R7 R8 R9)
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 64 == 0) mode_dual = ~mode_dual;
            if ($urandom % 40 == 0) sleep = ~sleep;
            bus_a = W'($urandom % 4096);
            bus_b = W'($urandom % 4096);
            wr_a  = 1'($urandom % 2);
            upd_a = 1'($urandom % 2);
            wr_b  = 1'($urandom % 2);
            upd_b = mode_dual ? 1'($urandom % 2) : ($urandom % 8 == 0);
            step();
            chk("R2 R5 random code_a", code_a, m_sa[3]);
            chk("R3 R4 R7 random code_b", code_b, m_sb[3]);
            chk("R8 random code_a_n", code_a_n, exp_comp(m_sa[3]));
            chk("R8 random code_b_n", code_b_n, exp_comp(m_sb[3]));
            chk("R9 random flag", {11'd0, asleep}, {11'd0, m_sleep});
        end
        finish_run();
    end

endmodule